// File: doc/BRIEF.md
# Interrupt Boundary Sequencer

This block sits beside a CPU core and settles, at every instruction boundary, which of three things the core does next. It can enter the non-maskable interrupt sequence, enter the maskable interrupt sequence, or fetch the next opcode. A non-maskable request is armed together with a horizontal cycle position. It only becomes due once the line's running cycle position has reached that value. A one-shot timer compare raises an internal interrupt line when the cycle position reaches the programmed value. That line is merged with an external interrupt pin into a single maskable request.

The block owns the effective interrupt-disable flag. Writes to that flag arrive as deferred requests. They are held and then folded in at the moment of the next decision, so the value the core would push to its stack is the already-updated one. The mask test still uses the flag as it stood before the update.

When the core reports that it sits in a wait-for-interrupt state, a boundary with nothing pending parks the block in a sleep state. Any due non-maskable request or any maskable request ends the sleep, whatever the mask says. The block then gives a wake strobe carrying the cycle penalty and an implied program-counter step of one, and makes the normal decision on the following cycle.

States: `SQ_IDLE` (waiting for a boundary), `SQ_SLEEP` (waiting for an interrupt), `SQ_WAKE` (wake strobe), `SQ_NMI`, `SQ_IRQ`, `SQ_FETCH` (one-cycle decision strobes). Transitions:
- IDLE→SLEEP: boundary with wait and no request.
- IDLE→WAKE: boundary with wait and a request.
- IDLE→NMI/IRQ/FETCH: boundary without wait.
- SLEEP→WAKE: a request appears.
- WAKE→NMI/IRQ/FETCH: decision.
- NMI/IRQ/FETCH→IDLE: always.

Top module: `irq_sequencer`

## Requirements
- R1: After reset no strobe is high, `wake_cycles` is 0, `iflag` is 1 and `irq_line` is 0; no non-maskable request is pending and the timer is disabled.
- R2: An armed non-maskable request is taken only at a boundary where `cycle_pos` >= its armed position; taking it clears it, so the next boundary does not take it again.
- R3: At a boundary where a non-maskable request is due and a maskable request is present and unmasked, `take_nmi` is given and the maskable request is left for a later boundary.
- R4: A maskable request is taken only when the interrupt-disable flag, as it stood before the deferred update at that decision, is 0; otherwise the boundary yields `do_fetch`.
- R5: The maskable request is the OR of `irq_line` and `ext_irq`; either one alone causes `take_irq` when unmasked.
- R6: The timer raises `irq_line` on the clock edge after `cycle_pos` >= the loaded position. It then disarms (one-shot), and `irq_line` stays high until `tmr_ack`. A loaded position of 0xFFFF never fires.
- R7: A pending flag request is applied at each NMI, IRQ or fetch decision, and `iflag` during the strobe shows the new value. A set request with the flag clear still lets the IRQ be taken, showing `iflag`=1. A clear request with the flag set yields a fetch showing `iflag`=0.
- R8: A boundary with `wait_i`=1 and no request gives no strobe until a request appears. A request, even a masked one, gives `wake` with `wake_cycles` = 2*CPU_CYC + DOT_CYC/2 (14 by default). On the next cycle it gives the normal decision.
- R9: Each evaluation gives exactly one of `take_nmi`, `take_irq`, `do_fetch`, each high for one cycle, followed by a cycle with all strobes low.
- R10: `flag_req_vld` with `flag_req_set`=1 requests set and with 0 requests clear. The latest request before a decision wins, and after being applied the request returns to none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction boundary, one-cycle pulse |
| wait_i | input | 1 | Core is in its wait-for-interrupt state |
| cycle_pos | input | 16 | Running cycle position within the line |
| nmi_arm | input | 1 | Arm a non-maskable request |
| nmi_pos | input | 16 | Trigger position captured with `nmi_arm` |
| tmr_load | input | 1 | Load the timer compare position |
| tmr_pos | input | 16 | Timer compare position (0xFFFF = disabled) |
| tmr_ack | input | 1 | Clear the internal timer interrupt line |
| ext_irq | input | 1 | External interrupt request |
| flag_req_vld | input | 1 | Deferred interrupt-disable change request |
| flag_req_set | input | 1 | 1 = set the flag, 0 = clear it |
| take_nmi | output | 1 | Enter the non-maskable sequence |
| take_irq | output | 1 | Enter the maskable sequence |
| do_fetch | output | 1 | Fetch the next opcode |
| wake | output | 1 | Leave the wait state, program counter steps by one |
| wake_cycles | output | 8 | Cycle penalty, valid with `wake` |
| iflag | output | 1 | Effective interrupt-disable flag |
| irq_line | output | 1 | Internal timer interrupt line |

## Verification
The decision is exercised with a lone request of each kind, with the non-maskable trigger position below and at the cycle position, and with both kinds present at once. Together these separate position gating from priority. Deferred set and clear requests are combined with the flag in both states, which shows that the mask test uses the old flag while the strobe reports the new one. Wait-state runs use a masked external request, a due non-maskable request and an idle stretch, so that wake-through-mask, the penalty value and the absence of spurious strobes while asleep are each seen at the ports.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_SLEEP = 3'd1,
        SQ_WAKE  = 3'd2,
        SQ_NMI   = 3'd3,
        SQ_IRQ   = 3'd4,
        SQ_FETCH = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_SET   = 2'd1,
        FR_CLEAR = 2'd2
    } flag_req_t;

endpackage

// File: rtl/nmi_track.sv
module nmi_track #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [POS_W-1:0] arm_pos,
    input  logic [POS_W-1:0] cycle_pos,
    input  logic             take,
    output logic             due,
    output logic [POS_W-1:0] pos_q
);
    localparam logic [POS_W-1:0] PARKED = '1;

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pos_q  <= PARKED;
        end else if (arm) begin
            pend_q <= 1'b1;
            pos_q  <= arm_pos;
        end else if (take) begin
            pend_q <= 1'b0;
            pos_q  <= PARKED;
        end
    end

    assign due = pend_q && (cycle_pos >= pos_q);

endmodule

// File: rtl/timer_cmp.sv
module timer_cmp #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [POS_W-1:0] load_pos,
    input  logic             ack,
    input  logic [POS_W-1:0] cycle_pos,
    output logic             line,
    output logic [POS_W-1:0] pos_q
);
    localparam logic [POS_W-1:0] OFF = '1;

    logic hit;

    assign hit = (pos_q != OFF) && (cycle_pos >= pos_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= OFF;
        end else if (load) begin
            pos_q <= load_pos;
        end else if (hit) begin
            pos_q <= OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line <= 1'b0;
        end else if (hit) begin
            line <= 1'b1;
        end else if (ack) begin
            line <= 1'b0;
        end
    end

endmodule

// File: rtl/flag_defer.sv
module flag_defer
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_vld,
    input  logic req_set,
    input  logic apply,
    output logic flag_q,
    output logic flag_next
);
    flag_req_t req_q;

    always_comb begin
        unique case (req_q)
            FR_SET:   flag_next = 1'b1;
            FR_CLEAR: flag_next = 1'b0;
            default:  flag_next = flag_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
        end else if (apply) begin
            flag_q <= flag_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= FR_NONE;
        end else if (req_vld) begin
            req_q <= req_set ? FR_SET : FR_CLEAR;
        end else if (apply) begin
            req_q <= FR_NONE;
        end
    end

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int POS_W   = 16,
    parameter int CPU_CYC = 6,
    parameter int DOT_CYC = 4,
    parameter int PEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             wait_i,
    input  logic [POS_W-1:0] cycle_pos,
    input  logic             nmi_arm,
    input  logic [POS_W-1:0] nmi_pos,
    input  logic             tmr_load,
    input  logic [POS_W-1:0] tmr_pos,
    input  logic             tmr_ack,
    input  logic             ext_irq,
    input  logic             flag_req_vld,
    input  logic             flag_req_set,
    output logic             take_nmi,
    output logic             take_irq,
    output logic             do_fetch,
    output logic             wake,
    output logic [PEN_W-1:0] wake_cycles,
    output logic             iflag,
    output logic             irq_line
);
    localparam int               PEN_VAL  = 2 * CPU_CYC + DOT_CYC / 2;
    localparam logic [PEN_W-1:0] WAKE_PEN = PEN_W'(PEN_VAL);

    seq_state_t      state_q, state_d;
    logic            nmi_due, irq_any, nmi_taking, apply, flag_next;
    logic [POS_W-1:0] nmi_pos_q, tmr_pos_q;

    nmi_track #(.POS_W(POS_W)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (nmi_arm),
        .arm_pos  (nmi_pos),
        .cycle_pos(cycle_pos),
        .take     (nmi_taking),
        .due      (nmi_due),
        .pos_q    (nmi_pos_q)
    );

    timer_cmp #(.POS_W(POS_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_pos (tmr_pos),
        .ack      (tmr_ack),
        .cycle_pos(cycle_pos),
        .line     (irq_line),
        .pos_q    (tmr_pos_q)
    );

    flag_defer u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (flag_req_vld),
        .req_set  (flag_req_set),
        .apply    (apply),
        .flag_q   (iflag),
        .flag_next(flag_next)
    );

    assign irq_any = irq_line | ext_irq;

    function automatic seq_state_t decide(input logic n_due, input logic i_any,
                                          input logic mask);
        if (n_due)
            return SQ_NMI;
        else if (i_any && !mask)
            return SQ_IRQ;
        else
            return SQ_FETCH;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (boundary) begin
                    if (wait_i)
                        state_d = (nmi_due || irq_any) ? SQ_WAKE : SQ_SLEEP;
                    else
                        state_d = decide(nmi_due, irq_any, iflag);
                end
            end
            SQ_SLEEP: begin
                if (nmi_due || irq_any)
                    state_d = SQ_WAKE;
            end
            SQ_WAKE:  state_d = decide(nmi_due, irq_any, iflag);
            SQ_NMI,
            SQ_IRQ,
            SQ_FETCH: state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    assign apply      = ((state_q == SQ_IDLE) || (state_q == SQ_WAKE)) &&
                        ((state_d == SQ_NMI) || (state_d == SQ_IRQ) ||
                         (state_d == SQ_FETCH));
    assign nmi_taking = (state_d == SQ_NMI) && (state_q != SQ_NMI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        take_nmi    = 1'b0;
        take_irq    = 1'b0;
        do_fetch    = 1'b0;
        wake        = 1'b0;
        wake_cycles = '0;
        unique case (state_q)
            SQ_NMI:   take_nmi = 1'b1;
            SQ_IRQ:   take_irq = 1'b1;
            SQ_FETCH: do_fetch = 1'b1;
            SQ_WAKE: begin
                wake        = 1'b1;
                wake_cycles = WAKE_PEN;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
    parameter int POS_W   = 16,
    parameter int CPU_CYC = 6,
    parameter int DOT_CYC = 4,
    parameter int PEN_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_nmi,
    input logic             take_irq,
    input logic             do_fetch,
    input logic             wake,
    input logic [PEN_W-1:0] wake_cycles,
    input logic             iflag,
    input logic             irq_line,
    input logic [POS_W-1:0] cycle_pos,
    input logic [POS_W-1:0] nmi_pos_q,
    input logic [POS_W-1:0] tmr_pos_q
);
    localparam logic [PEN_W-1:0] PEN_EXP = PEN_W'(2 * CPU_CYC + DOT_CYC / 2);
    localparam logic [POS_W-1:0] OFF     = '1;

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_nmi, take_irq, do_fetch, wake}));

    // R9
    take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi || take_irq || do_fetch) |=>
        !(take_nmi || take_irq || do_fetch || wake));

    // R8
    wake_then_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (take_nmi || take_irq || do_fetch));

    // R8
    wake_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (wake_cycles == PEN_EXP));

    // R4
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> !$past(iflag));

    // R2
    nmi_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_nmi) |-> ($past(cycle_pos) >= $past(nmi_pos_q)));

    // R2
    nmi_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_nmi) |-> (nmi_pos_q == OFF));

    // R6
    tmr_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_line) |-> ($past(tmr_pos_q) != OFF) &&
                            ($past(cycle_pos) >= $past(tmr_pos_q)));

endmodule

bind irq_sequencer irq_sequencer_chk #(
    .POS_W  (POS_W),
    .CPU_CYC(CPU_CYC),
    .DOT_CYC(DOT_CYC),
    .PEN_W  (PEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_nmi   (take_nmi),
    .take_irq   (take_irq),
    .do_fetch   (do_fetch),
    .wake       (wake),
    .wake_cycles(wake_cycles),
    .iflag      (iflag),
    .irq_line   (irq_line),
    .cycle_pos  (cycle_pos),
    .nmi_pos_q  (nmi_pos_q),
    .tmr_pos_q  (tmr_pos_q)
);

// File: tb/sim_irq_sequencer.sv
`timescale 1ns/1ps
module sim_irq_sequencer;

    localparam int K_NMI   = 1;
    localparam int K_IRQ   = 2;
    localparam int K_FETCH = 3;
    localparam int K_WAKE  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0, wait_i = 1'b0;
    logic [15:0] cycle_pos = '0;
    logic        nmi_arm = 1'b0;
    logic [15:0] nmi_pos = '0;
    logic        tmr_load = 1'b0;
    logic [15:0] tmr_pos = '0;
    logic        tmr_ack = 1'b0, ext_irq = 1'b0;
    logic        flag_req_vld = 1'b0, flag_req_set = 1'b0;
    logic        take_nmi, take_irq, do_fetch, wake, iflag, irq_line;
    logic [7:0]  wake_cycles;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int    exp_kind[$];
    bit    exp_flag[$];
    string exp_tag[$];

    always #2.5 clk = ~clk;

    irq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .wait_i(wait_i),
        .cycle_pos(cycle_pos), .nmi_arm(nmi_arm), .nmi_pos(nmi_pos),
        .tmr_load(tmr_load), .tmr_pos(tmr_pos), .tmr_ack(tmr_ack),
        .ext_irq(ext_irq), .flag_req_vld(flag_req_vld),
        .flag_req_set(flag_req_set), .take_nmi(take_nmi),
        .take_irq(take_irq), .do_fetch(do_fetch), .wake(wake),
        .wake_cycles(wake_cycles), .iflag(iflag), .irq_line(irq_line)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_item(input int kind, input bit flag, input string tag);
        exp_kind.push_back(kind);
        exp_flag.push_back(flag);
        exp_tag.push_back(tag);
    endtask

    // monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (rst_n && (take_nmi || take_irq || do_fetch || wake)) begin
            int kind;
            kind = take_nmi ? K_NMI : take_irq ? K_IRQ : do_fetch ? K_FETCH : K_WAKE;
            if (exp_kind.size() == 0) begin
                chk(1'b0, "R9 unexpected strobe", kind, 0);
            end else begin
                int  ek;
                bit  ef;
                string et;
                ek = exp_kind.pop_front();
                ef = exp_flag.pop_front();
                et = exp_tag.pop_front();
                chk(kind == ek, {et, " kind"}, kind, ek);
                if (kind == K_WAKE)
                    chk(wake_cycles == 8'd14, {et, " wake_cycles"}, wake_cycles, 14);
                else
                    chk(iflag == ef, {et, " iflag"}, iflag, ef);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_boundary();
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        tick(2);
    endtask

    task automatic flag_req(input bit set);
        flag_req_vld = 1'b1;
        flag_req_set = set;
        @(negedge clk);
        flag_req_vld = 1'b0;
    endtask

    task automatic arm_nmi(input logic [15:0] p);
        nmi_arm = 1'b1;
        nmi_pos = p;
        @(negedge clk);
        nmi_arm = 1'b0;
    endtask

    task automatic load_tmr(input logic [15:0] p);
        tmr_load = 1'b1;
        tmr_pos  = p;
        @(negedge clk);
        tmr_load = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        chk(!(take_nmi || take_irq || do_fetch || wake), "R1 strobes", 1, 0);
        chk(wake_cycles == 0, "R1 wake_cycles", wake_cycles, 0);
        chk(iflag == 1'b1, "R1 iflag", iflag, 1);
        chk(irq_line == 1'b0, "R1 irq_line", irq_line, 0);
        rst_n = 1'b1;
        tick(2);

        // R1 nothing pending after reset -> plain fetch
        expect_item(K_FETCH, 1'b1, "R1 idle fetch");
        pulse_boundary();

        // R2 NMI gated by position, then cleared
        cycle_pos = 16'd50;
        arm_nmi(16'd100);
        expect_item(K_FETCH, 1'b1, "R2 below position");
        pulse_boundary();
        cycle_pos = 16'd100;
        expect_item(K_NMI, 1'b1, "R2 at position");
        pulse_boundary();
        expect_item(K_FETCH, 1'b1, "R2 not retaken");
        pulse_boundary();

        // R4 masked external request yields fetch
        ext_irq = 1'b1;
        expect_item(K_FETCH, 1'b1, "R4 masked");
        pulse_boundary();
        // R7 clear request: gate uses old flag, strobe shows new flag
        flag_req(1'b0);
        expect_item(K_FETCH, 1'b0, "R7 clear then fetch");
        pulse_boundary();
        // R5 external line alone, unmasked
        expect_item(K_IRQ, 1'b0, "R5 external irq");
        pulse_boundary();
        // R7 set request with flag clear: IRQ taken, shows 1
        flag_req(1'b1);
        expect_item(K_IRQ, 1'b1, "R7 set still takes irq");
        pulse_boundary();
        ext_irq = 1'b0;
        // R10 request consumed
        expect_item(K_FETCH, 1'b1, "R10 consumed");
        pulse_boundary();
        // R10 latest wins (set then clear)
        flag_req(1'b1);
        flag_req(1'b0);
        expect_item(K_FETCH, 1'b0, "R10 latest wins");
        pulse_boundary();

        // R3 priority
        ext_irq = 1'b1;
        arm_nmi(16'd0);
        expect_item(K_NMI, 1'b0, "R3 nmi first");
        pulse_boundary();
        expect_item(K_IRQ, 1'b0, "R3 irq after");
        pulse_boundary();
        ext_irq = 1'b0;

        // R6 timer
        cycle_pos = 16'd150;
        load_tmr(16'd200);
        tick(2);
        chk(irq_line == 1'b0, "R6 below compare", irq_line, 0);
        cycle_pos = 16'd200;
        tick(1);
        chk(irq_line == 1'b1, "R6 fired", irq_line, 1);
        expect_item(K_IRQ, 1'b0, "R5 timer irq");
        pulse_boundary();
        tmr_ack = 1'b1;
        tick(1);
        tmr_ack = 1'b0;
        cycle_pos = 16'd250;
        tick(3);
        chk(irq_line == 1'b0, "R6 one-shot", irq_line, 0);
        load_tmr(16'hFFFF);
        cycle_pos = 16'hFFFF;
        tick(3);
        chk(irq_line == 1'b0, "R6 disabled", irq_line, 0);
        cycle_pos = 16'd10;

        // R8 wait with masked request
        flag_req(1'b1);
        expect_item(K_FETCH, 1'b1, "R8 setup mask");
        pulse_boundary();
        wait_i = 1'b1;
        pulse_boundary();
        wait_i = 1'b0;
        tick(4);
        chk(exp_kind.size() == 0, "R8 asleep no strobe", exp_kind.size(), 0);
        expect_item(K_WAKE, 1'b1, "R8 wake through mask");
        expect_item(K_FETCH, 1'b1, "R8 masked after wake");
        ext_irq = 1'b1;
        tick(3);
        ext_irq = 1'b0;
        tick(1);

        // R8 wait with due NMI wakes immediately
        arm_nmi(16'd5);
        wait_i = 1'b1;
        expect_item(K_WAKE, 1'b1, "R8 wake nmi");
        expect_item(K_NMI, 1'b1, "R8 nmi after wake");
        pulse_boundary();
        wait_i = 1'b0;
        tick(2);

        chk(exp_kind.size() == 0, "R9 all expected strobes seen", exp_kind.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule